// File: doc/BRIEF.md
# Stereo ADC Peak Level Meter

This block watches the sample stream of a two-channel audio converter and keeps, for each channel, the loudest absolute amplitude seen since that channel was last read. The peak is held as a 6-bit attenuation code in whole decibels below full scale. Code 0 means the peak was at full scale or within 1 dB of it. Code 63 means the peak is 63 dB or more below full scale, or that no sample has arrived since the last clear.

Samples arrive as two's-complement words with a channel tag and a valid strobe. A word-length select tells the block whether a word holds 16, 20 or 24 meaningful bits. A read request names a channel. The held code comes back one cycle later, and the channel restarts its measurement in the same step. A sample that lands in the read cycle is never lost: it becomes the first value of the new measurement.

Top module: `peak_meter_top`

## Requirements
- R1: Out of reset, `rd_valid` is 0, `rd_data` is 0, and both channels hold code 63, so a first read of either channel returns 63.
- R2: A read request (`rd_en` high with `rd_chan`) raises `rd_valid` for exactly one cycle, in the next cycle. `rd_data` then carries that channel's held code.
- R3: A read clears the channel it names. Without new samples, the next read of that channel returns 63.
- R4: Each channel keeps the smallest code (the largest amplitude) of all samples since its last clear. A quieter later sample leaves the held code unchanged.
- R5: A sample tagged `smp_chan`=0 updates only channel 0, and a sample tagged 1 updates only channel 1.
- R6: A sample's code is the count of thresholds T(j), for j = 1..63, that its normalized magnitude m lies strictly below, where T(j) = floor((2^23-1) * 10^(-j/20)). So m = T(j) gives code j-1, m = T(j)-1 gives code j, and m = 2^23-1 gives code 0.
- R7: The magnitude is the absolute value of the normalized 24-bit word. A negative sample gives the same code as the positive sample of equal size. The most negative word (0x800000) saturates to 2^23-1 and gives code 0.
- R8: `word_len`=0 takes `smp_data[15:0]` and shifts it left by 8. `word_len`=1 takes `smp_data[19:0]` and shifts it left by 4. `word_len`=2 or 3 takes all 24 bits. Bits above the selected length have no effect on the code.
- R9: When a sample and a read hit the same channel in one cycle, the read returns the code held before that sample, and the channel then holds that sample's code.
- R10: When a read of one channel coincides with a sample for the other channel, the sampled channel updates as usual.
- R11: A zero sample gives code 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_len | input | 2 | Sample word length: 0 = 16 bit, 1 = 20 bit, 2 or 3 = 24 bit |
| smp_valid | input | 1 | Sample strobe |
| smp_chan | input | 1 | Channel tag of the sample |
| smp_data | input | 24 | Two's-complement sample, right-aligned |
| rd_en | input | 1 | Read request, one cycle per read |
| rd_chan | input | 1 | Channel to read and clear |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 6 | Peak code of the read channel, in dB below full scale |

## Verification
The level conversion is probed on both sides of several thresholds (the first, a mid-range one, the 62nd and the 63rd), at exact full scale, at zero and at the most negative word. These points show whether each comparison is strict and whether any threshold value is off. Mixed loud and quiet sequences show whether the hold keeps the minimum code rather than the latest one. Words of each length are sent with junk in the unused upper bits, which exposes a wrong shift or a leaking bit. Reads that coincide with samples on the same channel and on the other channel show whether a sample is lost, or applied to the wrong side, when a clear happens.

// File: rtl/peak_meter_pkg.sv
package peak_meter_pkg;

  // Attenuation threshold j (1-based): floor(full_scale * 10^(-j/20)),
  // where full_scale is the largest positive value of a sw-bit word.
  function automatic int thr_val(input int j, input int sw);
    real fs;
    real r;
    fs = (2.0 ** (sw - 1)) - 1.0;
    r  = fs * (10.0 ** (-j / 20.0));
    return $rtoi(r);
  endfunction

endpackage

// File: rtl/peak_mag.sv
module peak_mag #(
  parameter int SAMPLE_W = 24,
  localparam int MAG_W   = SAMPLE_W - 1
) (
  input  logic [SAMPLE_W-1:0] raw,
  input  logic [1:0]          wl,
  output logic [MAG_W-1:0]    mag,
  output logic                sat_evt
);

  logic [SAMPLE_W-1:0] norm;
  logic [SAMPLE_W-1:0] neg_v;

  // Align the selected word to the top of the full-width field.
  always_comb begin
    case (wl)
      2'd0:    norm = {raw[15:0], {(SAMPLE_W-16){1'b0}}};
      2'd1:    norm = {raw[19:0], {(SAMPLE_W-20){1'b0}}};
      default: norm = raw;
    endcase
  end

  assign neg_v   = (~norm) + 1'b1;
  assign sat_evt = (norm == {1'b1, {MAG_W{1'b0}}});

  always_comb begin
    if (sat_evt)           mag = {MAG_W{1'b1}};
    else if (norm[SAMPLE_W-1]) mag = neg_v[MAG_W-1:0];
    else                   mag = norm[MAG_W-1:0];
  end

endmodule

// File: rtl/peak_db_quant.sv
module peak_db_quant #(
  parameter int SAMPLE_W = 24,
  parameter int CODE_W   = 6,
  localparam int MAG_W   = SAMPLE_W - 1,
  localparam int NUM_THR = (1 << CODE_W) - 1
) (
  input  logic [MAG_W-1:0]  mag,
  output logic [CODE_W-1:0] code
);

  logic [NUM_THR-1:0] below;

  // One comparator per 1 dB step; thresholds fall monotonically.
  for (genvar j = 1; j <= NUM_THR; j++) begin : g_thr
    localparam logic [MAG_W-1:0] THR = MAG_W'(peak_meter_pkg::thr_val(j, SAMPLE_W));
    assign below[j-1] = (mag < THR);
  end

  always_comb begin
    code = '0;
    for (int i = 0; i < NUM_THR; i++) code = code + CODE_W'(below[i]);
  end

endmodule

// File: rtl/peak_hold.sv
module peak_hold #(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic [CODE_W-1:0] code_in,
  input  logic              clr,
  output logic [CODE_W-1:0] pk
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pk <= '1;
    end else if (clr) begin
      pk <= upd ? code_in : '1;
    end else if (upd && (code_in < pk)) begin
      pk <= code_in;
    end
  end

endmodule

// File: rtl/peak_meter_top.sv
module peak_meter_top #(
  parameter int SAMPLE_W = 24,
  parameter int CODE_W   = 6,
  parameter int NUM_CH   = 2,
  localparam int MAG_W   = SAMPLE_W - 1,
  localparam int CH_W    = $clog2(NUM_CH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          word_len,
  input  logic                smp_valid,
  input  logic [CH_W-1:0]     smp_chan,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic                rd_en,
  input  logic [CH_W-1:0]     rd_chan,
  output logic                rd_valid,
  output logic [CODE_W-1:0]   rd_data
);

  logic [MAG_W-1:0]  smp_mag;
  logic [CODE_W-1:0] smp_code;
  logic              sat_evt;
  logic [CODE_W-1:0] hold_code [NUM_CH];

  peak_mag #(.SAMPLE_W(SAMPLE_W)) u_mag (
    .raw     (smp_data),
    .wl      (word_len),
    .mag     (smp_mag),
    .sat_evt (sat_evt)
  );

  peak_db_quant #(.SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W)) u_quant (
    .mag  (smp_mag),
    .code (smp_code)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic upd_g;
    logic clr_g;
    assign upd_g = smp_valid && (smp_chan == CH_W'(g));
    assign clr_g = rd_en && (rd_chan == CH_W'(g));
    peak_hold #(.CODE_W(CODE_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .upd     (upd_g),
      .code_in (smp_code),
      .clr     (clr_g),
      .pk      (hold_code[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= hold_code[rd_chan];
    end
  end

endmodule

// File: rtl/peak_meter_chk.sv
module peak_meter_chk #(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic              rd_chan,
  input logic              smp_valid,
  input logic              smp_chan,
  input logic              rd_valid,
  input logic [CODE_W-1:0] rd_data,
  input logic [CODE_W-1:0] pk0,
  input logic [CODE_W-1:0] pk1,
  input logic              sat_evt,
  input logic [CODE_W-1:0] smp_code
);

  p_rdv_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  p_rdv_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en));

  p_rd_data_ch0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_chan) |=> (rd_data == $past(pk0)));

  p_rd_data_ch1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_chan) |=> (rd_data == $past(pk1)));

  p_clear_ch0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_chan && !(smp_valid && !smp_chan)) |=> (pk0 == '1));

  p_clear_ch1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_chan && !(smp_valid && smp_chan)) |=> (pk1 == '1));

  p_hold_min_ch0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && !rd_chan) |=> (pk0 <= $past(pk0)));

  p_hold_min_ch1_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && rd_chan) |=> (pk1 <= $past(pk1)));

  p_sat_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sat_evt |-> (smp_code == '0));

  p_seed_ch0_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_chan && smp_valid && !smp_chan) |=> (pk0 == $past(smp_code)));

endmodule

bind peak_meter_top peak_meter_chk #(.CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_en     (rd_en),
  .rd_chan   (rd_chan),
  .smp_valid (smp_valid),
  .smp_chan  (smp_chan),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .pk0       (hold_code[0]),
  .pk1       (hold_code[1]),
  .sat_evt   (sat_evt),
  .smp_code  (smp_code)
);

// File: tb/peak_meter_top_bench.sv
module peak_meter_top_bench;

  localparam int FS = (1 << 23) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  word_len = 2'd2;
  logic        smp_valid = 1'b0;
  logic        smp_chan = 1'b0;
  logic [23:0] smp_data = '0;
  logic        rd_en = 1'b0;
  logic        rd_chan = 1'b0;
  logic        rd_valid;
  logic [5:0]  rd_data;

  int n_run = 0;
  int n_fail = 0;
  int exp_pk [2];
  int    q_exp [$];
  string q_req [$];

  always #5 clk = ~clk;

  peak_meter_top u_peak_meter_top (
    .clk(clk), .rst_n(rst_n), .word_len(word_len), .smp_valid(smp_valid),
    .smp_chan(smp_chan), .smp_data(smp_data), .rd_en(rd_en), .rd_chan(rd_chan),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // Threshold restated through exp/ln rather than a power.
  function automatic int bthr(input int j);
    return $rtoi($floor(FS * $exp(-j * $ln(10.0) / 20.0)));
  endfunction

  function automatic int bcode(input logic [23:0] raw, input logic [1:0] wl);
    int v;
    int m;
    int c;
    case (wl)
      2'd0:    v = int'($signed(raw[15:0])) * 256;
      2'd1:    v = int'($signed(raw[19:0])) * 16;
      default: v = int'($signed(raw));
    endcase
    m = (v < 0) ? -v : v;
    if (m > FS) m = FS;
    c = 0;
    for (int j = 1; j <= 63; j++) if (m < bthr(j)) c++;
    return c;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus, starting at a falling edge.
  task automatic cyc(input bit sv, input bit sc, input logic [23:0] sd,
                     input bit re, input bit rc, input string req);
    int c;
    smp_valid = sv; smp_chan = sc; smp_data = sd; rd_en = re; rd_chan = rc;
    c = bcode(sd, word_len);
    if (re) begin
      q_exp.push_back(exp_pk[rc]);
      q_req.push_back(req);
    end
    for (int ch = 0; ch < 2; ch++) begin
      if (re && rc == ch[0]) exp_pk[ch] = (sv && sc == ch[0]) ? c : 63;
      else if (sv && sc == ch[0] && c < exp_pk[ch]) exp_pk[ch] = c;
    end
    @(negedge clk);
    smp_valid = 1'b0; rd_en = 1'b0;
  endtask

  task automatic smp(input bit ch, input logic [23:0] d);
    cyc(1'b1, ch, d, 1'b0, 1'b0, "");
  endtask

  task automatic rd(input bit ch, input string req);
    cyc(1'b0, 1'b0, 24'd0, 1'b1, ch, req);
  endtask

  // Monitor / scoreboard.
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (q_exp.size() == 0) begin
        n_run++; n_fail++;
        $display("FAIL R2: actual rd_valid 1 expected 0");
      end else begin
        automatic int e = q_exp.pop_front();
        automatic string r = q_req.pop_front();
        check(r, int'(rd_data), e);
      end
    end
  end

  initial begin
    #2_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    exp_pk[0] = 63; exp_pk[1] = 63;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rd_valid", int'(rd_valid), 0);
    check("R1 rd_data", int'(rd_data), 0);
    rd(1'b0, "R1 ch0");
    rd(1'b1, "R1 ch1");

    // R6 half scale and R3 clear
    word_len = 2'd2;
    smp(1'b0, 24'h400000);
    rd(1'b0, "R6 half scale");
    rd(1'b0, "R3 after clear");

    // R4 loud between quiet samples
    smp(1'b0, 24'd1000);
    smp(1'b0, 24'h300000);
    smp(1'b0, 24'd50000);
    rd(1'b0, "R4 keep loudest");

    // R5 channel separation
    smp(1'b1, 24'h7FFFFF);
    rd(1'b0, "R5 ch0 untouched");
    rd(1'b1, "R5 ch1 full");

    // R6 threshold boundaries
    foreach (bnd_list[k]) begin
      automatic int j = bnd_list[k];
      smp(1'b0, 24'(bthr(j)));
      rd(1'b0, $sformatf("R6 at T(%0d)", j));
      smp(1'b1, 24'(bthr(j) - 1));
      rd(1'b1, $sformatf("R6 below T(%0d)", j));
    end
    smp(1'b0, 24'(FS));
    rd(1'b0, "R6 full scale");

    // R7 sign handling
    smp(1'b0, 24'(-bthr(10)));
    rd(1'b0, "R7 negative");
    smp(1'b1, 24'h800000);
    rd(1'b1, "R7 most negative");
    smp(1'b0, 24'hFFFFFF);
    rd(1'b0, "R7 minus one");

    // R11 zero
    smp(1'b1, 24'd0);
    rd(1'b1, "R11 zero");

    // R8 word lengths with junk in upper bits
    word_len = 2'd0;
    smp(1'b0, 24'hAB7FFF);
    rd(1'b0, "R8 16-bit full");
    smp(1'b0, 24'hFF0001);
    rd(1'b0, "R8 16-bit junk");
    smp(1'b1, 24'h5A4000);
    rd(1'b1, "R8 16-bit half");
    word_len = 2'd1;
    smp(1'b0, 24'hC80000);
    rd(1'b0, "R8 20-bit most negative");
    smp(1'b1, 24'h301000);
    rd(1'b1, "R8 20-bit junk");
    word_len = 2'd3;
    smp(1'b0, 24'h200000);
    rd(1'b0, "R8 code 3 as 24-bit");
    word_len = 2'd2;

    // R9 collision on the same channel
    smp(1'b0, 24'd30000);
    cyc(1'b1, 1'b0, 24'h7FFFFF, 1'b1, 1'b0, "R9 pre-sample value");
    rd(1'b0, "R9 seeded value");

    // R10 read one channel, sample the other
    smp(1'b1, 24'd20000);
    smp(1'b0, 24'h100000);
    cyc(1'b1, 1'b1, 24'h200000, 1'b1, 1'b0, "R10 ch0 read");
    rd(1'b1, "R10 ch1 updated");
    rd(1'b0, "R3 ch0 cleared");

    repeat (3) @(negedge clk);
    check("R2 pending reads", q_exp.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  int bnd_list [6] = '{1, 2, 10, 31, 62, 63};

endmodule